// File: doc/BRIEF.md
# CVSD Voice Decoder with Pair Averaging

This block turns a stream of compressed voice bytes into signed audio samples. It uses continuously variable slope delta demodulation. Each received bit is one up/down decision. A slope integrator grows during runs of identical bits and decays otherwise. An amplitude integrator moves by a step derived from that slope. Every two reconstructed values are averaged into one output sample, which acts as a simple low-pass filter. One input byte therefore yields four output samples.

Bytes arrive on a valid/ready input, and samples leave on a valid/ready output. The block consumes one bit per clock while it holds a byte and the output slot is free. Back-pressure on the output halts decoding until the slot drains. The first samples after reset are forced to silence so that the start of playback has no audible thump.

Top module: `cvsd_pair_decoder`

## Requirements
- R1: After reset, outValid is 0 and inByteReady is 1.
- R2: Bits of a byte are decoded most significant bit first, one per clock while decoding is not stalled.
- R3: A 3-bit history takes each new bit at its low end. If the updated history is 111 or 000, the unsigned 16-bit slope register rises by 200. Otherwise it falls by 200 when it is nonzero and stays at zero when it is zero.
- R4: The amplitude step is the updated slope shifted right by 5 plus 10. The signed 16-bit amplitude register adds the step for bit 1 and subtracts it for bit 0.
- R5: Each reconstructed value is the updated amplitude shifted right arithmetically by 4. An output sample is the sum of two consecutive reconstructed values, arithmetically halved (rounded toward minus infinity). A pair-phase flag, not the value, decides which reconstruction opens a pair.
- R6: Every input byte yields exactly four output samples.
- R7: The first 30 output samples after reset are 0. Later samples carry the averaged value.
- R8: While outValid is 1 and outReady is 0, outValid and outSample hold and no bit is decoded.
- R9: A new byte is accepted only when all eight bits of the held byte are used. With no stall, inByteReady stays low for seven cycles after an acceptance.
- R10: Reset clears both integrators and the pair state, and sets the history to 001.
- R11: The first sample of a byte that opens a pair is valid two cycles after the edge that accepts the byte.
- R12: Slope and amplitude wrap modulo 2^16 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inByteValid | input | 1 | Compressed byte offered |
| inByte | input | 8 | Compressed byte, MSB decoded first |
| inByteReady | output | 1 | Byte accepted at this edge when valid is high |
| outValid | output | 1 | Sample available |
| outReady | input | 1 | Consumer takes the sample |
| outSample | output | 16 | Signed averaged audio sample |

## Verification
An accepted byte decodes its first bit one cycle after the accepting edge. It decodes its second bit one cycle later, and that second bit raises outValid, so the first sample of a pair is due two cycles after acceptance. With no stall, each further sample follows two cycles after the last, and inByteReady returns high seven cycles after acceptance. The bench changes inputs on the falling edge and reads outputs a quarter period later. It compares every output handshake against a behavioural model that runs in bit order. It also counts the exact cycles of the latency and ready windows and holds a stalled sample against the next cycle.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
  // Strobes from the bit sequencer to the datapath
  typedef struct packed {
    logic step;    // decode one bit this cycle
    logic bitVal;  // the bit being decoded
  } cvsdStrobe_t;
endpackage

// File: rtl/cvsd_ctrl.sv
module cvsd_ctrl
  import cvsd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inByteValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic              inByteReady,
  input  logic              outValid,
  input  logic              outReady,
  output cvsdStrobe_t       strobe
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic              loaded;
  logic [IDX_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] shiftReg;
  logic              canStep;
  logic              lastBit;
  logic              take;

  assign canStep     = loaded && (!outValid || outReady);
  assign lastBit     = (bitIdx == LAST_IDX);
  assign inByteReady = !loaded || (lastBit && canStep);
  assign take        = inByteValid && inByteReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded   <= 1'b0;
      bitIdx   <= '0;
      shiftReg <= '0;
    end else if (take) begin
      loaded   <= 1'b1;
      bitIdx   <= '0;
      shiftReg <= inByte;
    end else if (canStep) begin
      shiftReg <= shiftReg << 1;
      bitIdx   <= bitIdx + 1'b1;
      if (lastBit) loaded <= 1'b0;
    end
  end

  assign strobe.step   = canStep;
  assign strobe.bitVal = shiftReg[BYTE_W-1];

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    inByteValid && inByteReady |=> !inByteReady);

  // R1
  reset_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> inByteReady);
endmodule

// File: rtl/cvsd_datapath.sv
module cvsd_datapath
  import cvsd_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int RUN_LEN      = 3,
  parameter int DELTA_MAX    = 200,
  parameter int DELTA_MIN    = 10,
  parameter int SLOPE_SHIFT  = 5,
  parameter int RECON_SHIFT  = 4,
  parameter int MUTE_SAMPLES = 30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cvsdStrobe_t              strobe,
  input  logic                     outReady,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample
);
  localparam int MUTE_W = $clog2(MUTE_SAMPLES + 1);
  localparam logic [DATA_W-1:0] SLOPE_INC = DATA_W'(DELTA_MAX);
  localparam logic [DATA_W-1:0] STEP_MIN  = DATA_W'(DELTA_MIN);
  localparam logic [MUTE_W-1:0] MUTE_LIM  = MUTE_W'(MUTE_SAMPLES);

  logic [RUN_LEN-1:0]        hist, histNext;
  logic [DATA_W-1:0]         slope, slopeNext, stepAmt;
  logic signed [DATA_W-1:0]  amp, ampNext, recon, acc, sampleNext;
  logic signed [DATA_W:0]    pairSum;
  logic                      phase, isRun, muted;
  logic [MUTE_W-1:0]         muteCnt;

  // run detector and slope integrator
  always_comb begin
    histNext = {hist[RUN_LEN-2:0], strobe.bitVal};
    isRun    = (&histNext) || (~|histNext);
    if (isRun)             slopeNext = slope + SLOPE_INC;
    else if (slope != '0)  slopeNext = slope - SLOPE_INC;
    else                   slopeNext = slope;
  end

  // amplitude integrator, scaling and pair averaging
  always_comb begin
    stepAmt    = (slopeNext >> SLOPE_SHIFT) + STEP_MIN;
    ampNext    = strobe.bitVal ? amp + $signed(stepAmt) : amp - $signed(stepAmt);
    recon      = ampNext >>> RECON_SHIFT;
    pairSum    = {recon[DATA_W-1], recon} + {acc[DATA_W-1], acc};
    muted      = (muteCnt < MUTE_LIM);
    sampleNext = muted ? '0 : pairSum[DATA_W:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist      <= {{(RUN_LEN-1){1'b0}}, 1'b1};
      slope     <= '0;
      amp       <= '0;
      acc       <= '0;
      phase     <= 1'b0;
      muteCnt   <= '0;
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      if (strobe.step) begin
        hist  <= histNext;
        slope <= slopeNext;
        amp   <= ampNext;
        if (!phase) begin
          acc   <= recon;
          phase <= 1'b1;
        end else begin
          phase     <= 1'b0;
          outSample <= sampleNext;
          if (muted) muteCnt <= muteCnt + 1'b1;
        end
      end
      if (strobe.step && phase) outValid <= 1'b1;
      else if (outReady)        outValid <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSample));

  // R3
  slope_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (slope == $past(slope) + SLOPE_INC) ||
                    (slope == $past(slope) - SLOPE_INC) ||
                    (slope == '0 && $past(slope) == '0));

  // R3
  slope_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(slope) && $stable(amp));

  // R7
  mute_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (muteCnt < MUTE_LIM) |-> outSample == '0);

  // R5
  pair_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> !phase);
endmodule

// File: rtl/cvsd_pair_decoder.sv
module cvsd_pair_decoder
  import cvsd_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int DATA_W       = 16,
  parameter int RUN_LEN      = 3,
  parameter int DELTA_MAX    = 200,
  parameter int DELTA_MIN    = 10,
  parameter int SLOPE_SHIFT  = 5,
  parameter int RECON_SHIFT  = 4,
  parameter int MUTE_SAMPLES = 30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inByteValid,
  input  logic [BYTE_W-1:0]        inByte,
  output logic                     inByteReady,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [DATA_W-1:0] outSample
);
  cvsdStrobe_t strobe;

  cvsd_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .inByteValid (inByteValid),
    .inByte      (inByte),
    .inByteReady (inByteReady),
    .outValid    (outValid),
    .outReady    (outReady),
    .strobe      (strobe)
  );

  cvsd_datapath #(
    .DATA_W       (DATA_W),
    .RUN_LEN      (RUN_LEN),
    .DELTA_MAX    (DELTA_MAX),
    .DELTA_MIN    (DELTA_MIN),
    .SLOPE_SHIFT  (SLOPE_SHIFT),
    .RECON_SHIFT  (RECON_SHIFT),
    .MUTE_SAMPLES (MUTE_SAMPLES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .outReady  (outReady),
    .outValid  (outValid),
    .outSample (outSample)
  );
endmodule

// File: tb/cvsd_pair_decoder_tb.sv
`timescale 1ns/1ps
module cvsd_pair_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inByteValid = 1'b0;
  logic [7:0] inByte = '0;
  logic inByteReady;
  logic outValid;
  logic outReady = 1'b1;
  logic signed [15:0] outSample;

  always #4 clk = ~clk;

  cvsd_pair_decoder dut_i (
    .clk(clk), .rstN(rstN), .inByteValid(inByteValid), .inByte(inByte),
    .inByteReady(inByteReady), .outValid(outValid), .outReady(outReady),
    .outSample(outSample)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int expQ[$];
  int byteCount = 0;
  int outCount = 0;

  // behavioural reference state
  int histM = 1, slopeM = 0, ampM = 0, phaseM = 0, accM = 0, emitM = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelBit(input int b);
    int stepM, rec, s;
    histM = ((histM << 1) | b) & 7;
    if (histM == 7 || histM == 0) slopeM = (slopeM + 200) & 16'hFFFF;
    else if (slopeM != 0)         slopeM = (slopeM - 200) & 16'hFFFF;
    stepM = ((slopeM >> 5) + 10) & 16'hFFFF;
    ampM  = (b != 0) ? ampM + stepM : ampM - stepM;
    ampM  = ampM & 16'hFFFF;
    if (ampM >= 32768) ampM -= 65536;
    rec = ampM >>> 4;
    if (phaseM == 0) begin
      accM = rec; phaseM = 1;
    end else begin
      s = (accM + rec) >>> 1;
      expQ.push_back((emitM < 30) ? 0 : s);
      emitM++;
      phaseM = 0;
    end
  endtask

  task automatic modelByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) modelBit(int'(b[i]));
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inByteValid = 1'b1; inByte = b;
    #1;
    while (!inByteReady) begin @(negedge clk); #1; end
    @(negedge clk);
    inByteValid = 1'b0;
    modelByte(b);
    byteCount++;
  endtask

  // output monitor: a quarter period after the falling edge
  bit prevStall = 0;
  logic signed [15:0] prevSample = '0;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rstN && !finished) begin
        if (prevStall) begin
          // R8 sample held while stalled
          check(outValid === 1'b1 && outSample === prevSample, "R8 hold",
                int'(outSample), int'(prevSample));
        end
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R6 extra sample", int'(outSample), 0);
          end else begin
            int e;
            e = expQ.pop_front();
            if (outCount < 30)
              check(int'(outSample) == 0, "R7 muted sample", int'(outSample), 0);
            check(int'(outSample) == e, "R2 R3 R4 R5 R10 R12 sample",
                  int'(outSample), e);
            outCount++;
          end
        end
        prevStall  = outValid && !outReady;
        prevSample = outSample;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      finished = 1;
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [15:0] rl;
    bit stopToggle;
    int lowCnt;
    lf = 16'hACE1; rl = 16'h1D2B; stopToggle = 0;

    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check(outValid === 1'b0, "R1 outValid", int'(outValid), 0);
    check(inByteReady === 1'b1, "R1 inByteReady", int'(inByteReady), 1);
    @(negedge clk); rstN = 1'b1;
    #2;
    check(outValid === 1'b0 && inByteReady === 1'b1, "R1 after release",
          int'(outValid), 0);

    // R11 latency of the first sample
    sendByte(8'hFF);
    #2; check(outValid === 1'b0, "R11 cycle1", int'(outValid), 0);
    @(negedge clk); #2; check(outValid === 1'b0, "R11 cycle2", int'(outValid), 0);
    @(negedge clk); #2; check(outValid === 1'b1, "R11 cycle3", int'(outValid), 1);
    repeat (8) @(negedge clk);

    // R9 ready stays low seven cycles after acceptance
    sendByte(8'hA5);
    lowCnt = 0;
    #1;
    while (!inByteReady && lowCnt < 20) begin
      lowCnt++;
      @(negedge clk); #1;
    end
    check(lowCnt == 7, "R9 ready-low cycles", lowCnt, 7);

    // assorted patterns, output always ready
    sendByte(8'h00); sendByte(8'h00); sendByte(8'hAA); sendByte(8'h55);
    sendByte(8'hF0); sendByte(8'h0F); sendByte(8'h80); sendByte(8'h01);
    sendByte(8'hCC); sendByte(8'h33);
    // long runs drive both integrators through their wrap (R12)
    for (int i = 0; i < 120; i++) sendByte(8'hFF);
    for (int i = 0; i < 60; i++)  sendByte(8'h00);
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sendByte(lf[7:0]);
    end

    // random back-pressure (R8)
    fork
      begin
        for (int i = 0; i < 80; i++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          sendByte(lf[7:0]);
        end
        stopToggle = 1;
      end
      begin
        while (!stopToggle) begin
          @(negedge clk);
          rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
          outReady = rl[1] & rl[4];
        end
        outReady = 1'b1;
      end
    join

    repeat (40) @(negedge clk);
    #3;
    // R6 four samples per byte
    check(expQ.size() == 0, "R6 pending samples", expQ.size(), 0);
    check(outCount == 4 * byteCount, "R6 sample count", outCount, 4 * byteCount);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule